// File: doc/BRIEF.md
# Interrupt Acknowledge Timing Sequencer

This block sits next to a multi-cycle processor core and decides at which instruction boundary a pending interrupt is taken. The core reports the clock index it is executing, counted from 1, together with the length of the current instruction. An index of 0 means the core is idle. The sequencer keeps one request flag per maskable source plus a non-maskable flag. It combines them with per-source mask bits and a global enable bit, and at the last clock of each instruction it either lets the core continue or starts an acknowledge sequence.

Once a request is accepted, the block holds the core stalled for a fixed number of cycles, eight by default. In the third and fourth of those cycles it offers two pushes on a valid/ready interface: first the status word, then the program counter. The core's stack logic accepts each push by raising `push_ready`. While `push_ready` is low, the offered push stays on the interface unchanged and the sequence waits, so back-pressure lengthens the stall cycle for cycle. In the final stall cycle the block presents the service-routine address with a one-cycle load strobe.

A request only counts at a boundary if it was already eligible one clock earlier. A flag that first appears in the last clock of an instruction therefore slips to the end of the next instruction. Accesses to the flag or mask registers during the boundary clock also postpone the decision.

Top module: `irq_ack_timer`

## Requirements
- R1: After reset, `stall`, `push_valid`, `vec_load`, `int_en`, `nmi_pend` and every bit of `irq_pend` are 0.
- R2: The last clock of an instruction is the cycle in which `ex_idx` equals `ex_len`, with `ex_len` between 4 and 10. Suppose a request is eligible in clock n-1 of an n-clock instruction and is still eligible in clock n. The request is then accepted at the end of clock n, and `stall` is 1 in the following cycle.
- R3: A request flag that first reads 1 in the last clock of an instruction is not accepted at that boundary. It is accepted at the end of the next instruction.
- R4: With `push_ready` held at 1, `stall` stays high for exactly 8 cycles per acknowledge. From the first stall cycle onward, the serviced source's pending flag is 0.
- R5: `vec_load` is high for one cycle, the last stall cycle. In that cycle `vec_addr` is VEC_BASE for the non-maskable request, and VEC_BASE + (i+1)*VEC_STEP for maskable source i.
- R6: If `flag_acc` or `mask_acc` is high in the boundary clock, nothing is accepted at that boundary. The request stays pending.
- R7: Acceptance clears `int_en`, and the clear wins over a simultaneous `ei_strobe`. Otherwise `ei_strobe` sets `int_en`, which lets a service routine accept a further request.
- R8: A maskable source is eligible only if its flag is 1, its mask bit is 0 and `int_en` is 1. The non-maskable request is eligible whenever its flag is 1.
- R9: `push_valid` is high in the third stall cycle with `push_kind` 0 (status), and in the fourth with `push_kind` 1 (program counter). While `push_ready` is 0, `push_valid` and `push_kind` hold and the sequence waits.
- R10: When several requests are eligible at the same boundary, the non-maskable one is taken first, then the maskable source with the lowest index.
- R11: A request whose eligibility is lost in the boundary clock (for example, its mask is set) is not accepted, and its flag stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_idx | input | IDX_W | Current clock index of the executing instruction, 0 when idle |
| ex_len | input | IDX_W | Length in clocks of the executing instruction |
| irq_set | input | NSRC | One-cycle pulses that raise maskable request flags |
| irq_mask | input | NSRC | Mask bits, 1 blocks the source |
| nmi_set | input | 1 | Pulse that raises the non-maskable request flag |
| flag_acc | input | 1 | Flag register is being accessed |
| mask_acc | input | 1 | Mask register is being accessed |
| ei_strobe | input | 1 | Enable-interrupt instruction executed |
| push_ready | input | 1 | Stack logic accepts the offered push |
| stall | output | 1 | Core must hold while high |
| push_valid | output | 1 | A push is offered |
| push_kind | output | 1 | 0 status word, 1 program counter |
| vec_load | output | 1 | Load `vec_addr` into the program counter |
| vec_addr | output | VEC_W | Service-routine address |
| int_en | output | 1 | Global maskable enable |
| irq_pend | output | NSRC | Maskable request flags |
| nmi_pend | output | 1 | Non-maskable request flag |

## Verification
The bench builds the block with six maskable sources, VEC_BASE of 256 and VEC_STEP of 4. These values put sources above index 3 in play, so the lowest-index rule is checked between indices 1 and 4, and every vector produced is distinct from the others. The default 8-cycle sequence and the 4-to-10 length range are kept. This makes the shortest and longest instructions, and the n-1 versus last-clock split at both ends, reachable.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

  typedef enum logic {
    PK_STATUS = 1'b0,
    PK_PC     = 1'b1
  } push_kind_e;

  localparam int STEP_PUSH_ST = 2;
  localparam int STEP_PUSH_PC = 3;

  function automatic int unsigned vec_of(input int unsigned base, input int unsigned step,
                                         input logic nmi, input int unsigned idx);
    return nmi ? base : base + (idx + 1) * step;
  endfunction

endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int NSRC = 4,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_set,
  input  logic [NSRC-1:0]  irq_mask,
  input  logic             nmi_set,
  input  logic             int_en,
  input  logic             clr,
  input  logic             clr_nmi,
  input  logic [SRC_W-1:0] clr_idx,
  output logic [NSRC-1:0]  irq_pend,
  output logic             nmi_pend,
  output logic [NSRC-1:0]  cand_irq,
  output logic             cand_nmi
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic pend_r;
    logic prev_r;
    logic elig;

    assign elig = pend_r && !irq_mask[g] && int_en;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_r <= 1'b0;
        prev_r <= 1'b0;
      end else begin
        if (irq_set[g])
          pend_r <= 1'b1;
        else if (clr && !clr_nmi && clr_idx == SRC_W'(g))
          pend_r <= 1'b0;
        prev_r <= elig;
      end
    end

    assign irq_pend[g] = pend_r;
    assign cand_irq[g] = elig && prev_r;
  end

  logic nmi_r;
  logic nmi_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_r    <= 1'b0;
      nmi_prev <= 1'b0;
    end else begin
      if (nmi_set)
        nmi_r <= 1'b1;
      else if (clr && clr_nmi)
        nmi_r <= 1'b0;
      nmi_prev <= nmi_r;
    end
  end

  assign nmi_pend = nmi_r;
  assign cand_nmi = nmi_r && nmi_prev;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 4,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  cand,
  output logic             found,
  output logic [SRC_W-1:0] idx
);

  always_comb begin
    found = |cand;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) idx = SRC_W'(i);
    end
  end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
#(
  parameter int ACK_LEN  = 8,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 2,
  parameter int SRC_W    = 2,
  localparam int STEP_W  = $clog2(ACK_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_nmi,
  input  logic [SRC_W-1:0] start_idx,
  input  logic             push_ready,
  output logic             stall,
  output logic             push_valid,
  output push_kind_e       push_kind,
  output logic             vec_load,
  output logic [VEC_W-1:0] vec_addr
);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic              tgt_nmi_q;
  logic [SRC_W-1:0]  tgt_idx_q;
  logic              wait_push;
  logic              last_step;

  assign last_step  = (step_q == STEP_W'(ACK_LEN - 1));
  assign push_valid = busy_q && (step_q == STEP_W'(STEP_PUSH_ST) || step_q == STEP_W'(STEP_PUSH_PC));
  assign push_kind  = (step_q == STEP_W'(STEP_PUSH_PC)) ? PK_PC : PK_STATUS;
  assign wait_push  = push_valid && !push_ready;
  assign stall      = busy_q;
  assign vec_load   = busy_q && last_step;
  assign vec_addr   = vec_load
                    ? VEC_W'(vec_of(VEC_BASE, VEC_STEP, tgt_nmi_q, int'(tgt_idx_q)))
                    : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      step_q    <= '0;
      tgt_nmi_q <= 1'b0;
      tgt_idx_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q    <= 1'b1;
        step_q    <= '0;
        tgt_nmi_q <= start_nmi;
        tgt_idx_q <= start_idx;
      end
    end else if (!wait_push) begin
      if (last_step) busy_q <= 1'b0;
      else           step_q <= step_q + 1'b1;
    end
  end

endmodule

// File: rtl/irq_ack_timer.sv
module irq_ack_timer
  import irq_ack_pkg::*;
#(
  parameter int NSRC     = 4,
  parameter int LEN_MIN  = 4,
  parameter int LEN_MAX  = 10,
  parameter int ACK_LEN  = 8,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 2,
  localparam int IDX_W   = $clog2(LEN_MAX + 1),
  localparam int SRC_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ex_idx,
  input  logic [IDX_W-1:0] ex_len,
  input  logic [NSRC-1:0]  irq_set,
  input  logic [NSRC-1:0]  irq_mask,
  input  logic             nmi_set,
  input  logic             flag_acc,
  input  logic             mask_acc,
  input  logic             ei_strobe,
  input  logic             push_ready,
  output logic             stall,
  output logic             push_valid,
  output logic             push_kind,
  output logic             vec_load,
  output logic [VEC_W-1:0] vec_addr,
  output logic             int_en,
  output logic [NSRC-1:0]  irq_pend,
  output logic             nmi_pend
);

  logic [NSRC-1:0]  cand_irq;
  logic             cand_nmi;
  logic             found;
  logic [SRC_W-1:0] pick_idx;
  logic             len_ok;
  logic             boundary;
  logic             take;
  logic             ie_q;
  push_kind_e       kind_w;

  assign len_ok   = (ex_len >= IDX_W'(LEN_MIN)) && (ex_len <= IDX_W'(LEN_MAX));
  assign boundary = len_ok && (ex_idx == ex_len) && !stall;
  assign take     = boundary && !(flag_acc || mask_acc) && (cand_nmi || found);

  always_ff @(posedge clk) begin
    if (!rst_n)         ie_q <= 1'b0;
    else if (take)      ie_q <= 1'b0;
    else if (ei_strobe) ie_q <= 1'b1;
  end

  assign int_en = ie_q;

  irq_src_flags #(.NSRC(NSRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_set  (irq_set),
    .irq_mask (irq_mask),
    .nmi_set  (nmi_set),
    .int_en   (ie_q),
    .clr      (take),
    .clr_nmi  (cand_nmi),
    .clr_idx  (pick_idx),
    .irq_pend (irq_pend),
    .nmi_pend (nmi_pend),
    .cand_irq (cand_irq),
    .cand_nmi (cand_nmi)
  );

  irq_pick #(.NSRC(NSRC)) u_pick (
    .cand  (cand_irq),
    .found (found),
    .idx   (pick_idx)
  );

  irq_ack_seq #(
    .ACK_LEN  (ACK_LEN),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP),
    .SRC_W    (SRC_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take),
    .start_nmi  (cand_nmi),
    .start_idx  (pick_idx),
    .push_ready (push_ready),
    .stall      (stall),
    .push_valid (push_valid),
    .push_kind  (kind_w),
    .vec_load   (vec_load),
    .vec_addr   (vec_addr)
  );

  assign push_kind = (kind_w == PK_PC);

endmodule

// File: rtl/irq_ack_timer_chk.sv
module irq_ack_timer_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] ex_idx,
  input logic [IDX_W-1:0] ex_len,
  input logic             flag_acc,
  input logic             mask_acc,
  input logic             push_ready,
  input logic             stall,
  input logic             push_valid,
  input logic             push_kind,
  input logic             vec_load,
  input logic             int_en,
  input logic             nmi_pend
);

  AST_TAKE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(ex_idx == ex_len)); // R2

  AST_HOLD_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> !$past(flag_acc || mask_acc)); // R6

  AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> !int_en); // R7

  AST_MASKABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stall) && !$past(nmi_pend)) |-> $past(int_en)); // R8

  AST_LOAD_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> (stall && !push_valid)); // R5

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |=> !vec_load); // R5

  AST_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_kind))); // R9

  AST_PUSH_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> stall); // R9

endmodule

bind irq_ack_timer irq_ack_timer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ex_idx     (ex_idx),
  .ex_len     (ex_len),
  .flag_acc   (flag_acc),
  .mask_acc   (mask_acc),
  .push_ready (push_ready),
  .stall      (stall),
  .push_valid (push_valid),
  .push_kind  (push_kind),
  .vec_load   (vec_load),
  .int_en     (int_en),
  .nmi_pend   (nmi_pend)
);

// File: tb/sim_irq_ack_timer.sv
`timescale 1ns/1ps
module sim_irq_ack_timer;

  localparam int NSRC  = 6;
  localparam int BASE  = 256;
  localparam int STEP  = 4;
  localparam int IDX_W = 4;
  localparam int VEC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IDX_W-1:0] ex_idx = '0;
  logic [IDX_W-1:0] ex_len = 4'd4;
  logic [NSRC-1:0]  irq_set = '0;
  logic [NSRC-1:0]  irq_mask = '0;
  logic             nmi_set = 1'b0;
  logic             flag_acc = 1'b0;
  logic             mask_acc = 1'b0;
  logic             ei_strobe = 1'b0;
  logic             push_ready = 1'b1;
  logic             stall, push_valid, push_kind, vec_load, int_en, nmi_pend;
  logic [VEC_W-1:0] vec_addr;
  logic [NSRC-1:0]  irq_pend;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  int    exp_vec[$];
  int    exp_len[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  irq_ack_timer #(
    .NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(BASE), .VEC_STEP(STEP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ex_idx(ex_idx), .ex_len(ex_len),
    .irq_set(irq_set), .irq_mask(irq_mask), .nmi_set(nmi_set),
    .flag_acc(flag_acc), .mask_acc(mask_acc), .ei_strobe(ei_strobe),
    .push_ready(push_ready), .stall(stall), .push_valid(push_valid),
    .push_kind(push_kind), .vec_load(vec_load), .vec_addr(vec_addr),
    .int_en(int_en), .irq_pend(irq_pend), .nmi_pend(nmi_pend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int vsrc(input int i);
    return BASE + (i + 1) * STEP;
  endfunction

  task automatic expect_ack(input int vec, input int len, input string tag);
    exp_vec.push_back(vec);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
  endtask

  // Monitor: counts stall cycles, records the vector, compares on stall fall.
  initial begin
    int cnt;
    int seen;
    cnt  = 0;
    seen = -1;
    forever begin
      @(negedge clk);
      if (stall) begin
        cnt++;
        if (vec_load) seen = int'(vec_addr);
      end else if (cnt > 0) begin
        if (exp_vec.size() == 0) begin
          chk(1'b0, "R2 unexpected acknowledge", seen, -1);
        end else begin
          int    ev;
          int    el;
          string et;
          ev = exp_vec.pop_front();
          el = exp_len.pop_front();
          et = exp_tag.pop_front();
          chk(seen == ev, {et, " R5 vector"}, seen, ev);
          chk(cnt == el, {et, " R4 stall length"}, cnt, el);
        end
        cnt  = 0;
        seen = -1;
      end
    end
  end

  // src == NSRC selects the non-maskable request; acc_sel 1 flag, 2 mask.
  task automatic instr(input int len, input int set_at, input int src,
                       input int acc_at, input int acc_sel,
                       input int mask_at, input int msrc);
    ex_len = IDX_W'(len);
    for (int i = 1; i <= len; i++) begin
      ex_idx   = IDX_W'(i);
      irq_set  = '0;
      nmi_set  = 1'b0;
      if (i == set_at - 1 && src >= 0) begin
        if (src == NSRC) nmi_set = 1'b1;
        else irq_set[src] = 1'b1;
      end
      flag_acc = (i == acc_at) && (acc_sel == 1);
      mask_acc = (i == acc_at) && (acc_sel == 2);
      if (i == mask_at) irq_mask[msrc] = 1'b1;
      @(negedge clk);
    end
    ex_idx   = '0;
    irq_set  = '0;
    nmi_set  = 1'b0;
    flag_acc = 1'b0;
    mask_acc = 1'b0;
  endtask

  task automatic plain(input int len);
    instr(len, -1, -1, -1, 0, -1, 0);
  endtask

  task automatic wait_idle();
    while (stall) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ei();
    ei_strobe = 1'b1;
    @(negedge clk);
    ei_strobe = 1'b0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] bits, input logic nmi);
    irq_set = bits;
    nmi_set = nmi;
    @(negedge clk);
    irq_set = '0;
    nmi_set = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!stall && !push_valid && !vec_load, "R1 outputs idle", int'(stall), 0);
    chk(!int_en && !nmi_pend && irq_pend == '0, "R1 flags clear", int'(irq_pend), 0);

    // R7 enable strobe
    ei();
    chk(int_en == 1'b1, "R7 ei sets enable", int'(int_en), 1);

    // R2 flag visible at clock n-1 of a 4-clock instruction
    expect_ack(vsrc(0), 8, "R2");
    instr(4, 3, 0, -1, 0, -1, 0);
    chk(stall == 1'b1, "R2 accepted at boundary", int'(stall), 1);
    chk(irq_pend[0] == 1'b0, "R4 flag cleared", int'(irq_pend[0]), 0);
    chk(int_en == 1'b0, "R7 enable cleared on accept", int'(int_en), 0);
    wait_idle();

    // R3 flag first visible in the last clock
    ei();
    expect_ack(vsrc(2), 8, "R3");
    instr(6, 6, 2, -1, 0, -1, 0);
    chk(stall == 1'b0, "R3 not taken at same boundary", int'(stall), 0);
    chk(irq_pend[2] == 1'b1, "R3 still pending", int'(irq_pend[2]), 1);
    plain(5);
    chk(stall == 1'b1, "R3 taken after next instruction", int'(stall), 1);
    wait_idle();

    // R8 masked source
    ei();
    irq_mask[1] = 1'b1;
    instr(5, 2, 1, -1, 0, -1, 0);
    chk(stall == 1'b0, "R8 masked not taken", int'(stall), 0);
    chk(irq_pend[1] == 1'b1, "R8 masked stays pending", int'(irq_pend[1]), 1);
    irq_mask[1] = 1'b0;
    expect_ack(vsrc(1), 8, "R8");
    plain(5);
    chk(stall == 1'b1, "R8 unmasked taken", int'(stall), 1);
    wait_idle();

    // R8 global enable low blocks maskable
    pulse(6'b001000, 1'b0);
    plain(4);
    chk(stall == 1'b0, "R8 enable low blocks", int'(stall), 0);
    ei();
    expect_ack(vsrc(3), 8, "R8");
    plain(4);
    chk(stall == 1'b1, "R8 taken after enable", int'(stall), 1);
    wait_idle();

    // R8 non-maskable ignores enable
    expect_ack(BASE, 8, "R8 nmi");
    instr(7, 2, NSRC, -1, 0, -1, 0);
    chk(stall == 1'b1, "R8 nmi taken with enable low", int'(stall), 1);
    wait_idle();
    chk(nmi_pend == 1'b0, "R4 nmi flag cleared", int'(nmi_pend), 0);

    // R10 lowest index first
    pulse(6'b010010, 1'b0);
    ei();
    expect_ack(vsrc(1), 8, "R10");
    plain(4);
    wait_idle();
    chk(irq_pend[4] == 1'b1, "R10 higher index waits", int'(irq_pend[4]), 1);
    ei();
    expect_ack(vsrc(4), 8, "R10");
    plain(4);
    wait_idle();

    // R10 non-maskable beats maskable
    ei();
    pulse(6'b000001, 1'b1);
    expect_ack(BASE, 8, "R10 nmi");
    plain(5);
    wait_idle();
    chk(irq_pend[0] == 1'b1, "R10 maskable left pending", int'(irq_pend[0]), 1);
    ei();
    expect_ack(vsrc(0), 8, "R10");
    plain(5);
    wait_idle();

    // R6 register access in the boundary clock holds pending
    ei();
    pulse(6'b100000, 1'b0);
    instr(6, -1, -1, 6, 1, -1, 0);
    chk(stall == 1'b0, "R6 flag access holds", int'(stall), 0);
    instr(4, -1, -1, 4, 2, -1, 0);
    chk(stall == 1'b0, "R6 mask access holds", int'(stall), 0);
    chk(irq_pend[5] == 1'b1, "R6 still pending", int'(irq_pend[5]), 1);
    expect_ack(vsrc(5), 8, "R6");
    plain(4);
    chk(stall == 1'b1, "R6 taken once access ends", int'(stall), 1);
    wait_idle();

    // R9 back-pressure on the status push
    ei();
    pulse(6'b000100, 1'b0);
    push_ready = 1'b0;
    expect_ack(vsrc(2), 10, "R9");
    plain(4);
    @(negedge clk);
    @(negedge clk);
    chk(push_valid && push_kind == 1'b0, "R9 status push offered", int'(push_kind), 0);
    @(negedge clk);
    chk(push_valid && push_kind == 1'b0, "R9 status push held", int'(push_valid), 1);
    @(negedge clk);
    push_ready = 1'b1;
    @(negedge clk);
    chk(push_valid && push_kind == 1'b1, "R9 pc push follows", int'(push_kind), 1);
    wait_idle();

    // R2 longest instruction, flag at clock 9
    ei();
    expect_ack(vsrc(3), 8, "R2 len10");
    instr(10, 9, 3, -1, 0, -1, 0);
    chk(stall == 1'b1, "R2 len10 taken", int'(stall), 1);
    wait_idle();

    // R11 eligibility lost in the boundary clock
    ei();
    instr(6, 2, 4, -1, 0, 6, 4);
    chk(stall == 1'b0, "R11 not taken", int'(stall), 0);
    chk(irq_pend[4] == 1'b1, "R11 stays pending", int'(irq_pend[4]), 1);
    irq_mask[4] = 1'b0;
    expect_ack(vsrc(4), 8, "R11");
    plain(4);
    wait_idle();

    // R7 nested acceptance inside a service routine
    ei();
    expect_ack(vsrc(0), 8, "R7");
    instr(4, 2, 0, -1, 0, -1, 0);
    wait_idle();
    ei();
    expect_ack(vsrc(1), 8, "R7 nested");
    instr(5, 2, 1, -1, 0, -1, 0);
    chk(stall == 1'b1, "R7 nested taken", int'(stall), 1);
    wait_idle();

    repeat (3) @(negedge clk);
    chk(exp_vec.size() == 0, "R5 all expected acks seen", exp_vec.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R2 watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule